// File: doc/BRIEF.md
# SMBus Target Register Responder

This block is a bus target for a two-wire SMBus segment. It watches the SCL and SDA lines, which reach it already synchronized to the system clock. It takes part in the bus only by pulling SDA low through an open-drain enable. It answers transactions aimed at the 7-bit address on its `dev_addr` input, and it ignores all other traffic until the next bus condition.

Behind the bus logic sits a small register file, eight bytes by default. The command byte of a write transaction selects a register, and any bytes that follow are stored there and in the registers after it. A read starts wherever the register pointer stands. The pointer survives a repeated START and also the end of a transaction. This lets a host do byte-data and word-data reads and writes, and it lets a plain receive-byte read return the register that was touched last.

The host ends a read by answering a byte with NACK. The target then releases SDA and stays silent until the next START or STOP.

Top module: `smb_target_regs`

## Requirements
- R1: The first byte after any START is seven address bits, MSB first, followed by a direction bit (1 = read, 0 = write). When the address equals `dev_addr`, the target pulls SDA low for the ninth clock.
- R2: For an address that does not match, the target never asserts `sda_oe` and changes no register until the next START or STOP.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START, including a repeated START part-way through a byte, clears the bit and byte counters so that the next byte is taken as an address. A STOP releases SDA.
- R4: In a write transaction, the byte after the address is a command byte. Its value modulo NUM_REGS (the low three bits with the default of 8) selects a register and sets the pointer to it.
- R5: Data bytes after the command byte are written in order. The first goes to the selected register and each later byte goes to the next index, wrapping from NUM_REGS-1 to 0. The pointer is left on the last register written.
- R6: Read data is sent MSB first. The first byte comes from the pointer and each byte the host ACKs is followed by the next index, with wrap. A word therefore comes out low byte (pointer) then high byte (pointer+1). The pointer is left on the last register read.
- R7: A read with no command byte in front of it returns the register under the pointer. The pointer is kept across STOP and across a repeated START.
- R8: After the host answers a read byte with NACK (SDA high on the ninth clock), the target keeps `sda_oe` low until the next START or STOP.
- R9: `sda_oe` changes only while SCL is low, on the first clock edge after SCL falls. Incoming bits are taken on the rising edge of SCL.
- R10: Reset leaves register i holding 0xA0+i (modulo 256), the pointer at 0 and SDA released.
- R11: The target address is taken from `dev_addr` at each address byte, so changing it between transactions moves the target to the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (the wired bus value) |
| dev_addr | input | 7 | Address this target answers to |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Every response is due on the first clock edge after the target sees the SCL edge that causes it: an acknowledge, a released line or the next read bit appears one cycle after SCL falls, and a received bit is taken one cycle after SCL rises. The bench holds each bus phase for four clocks and samples SDA in the middle of SCL high. Every result is therefore read three cycles after it settles and well before the next edge. One directed test measures the one-cycle delay exactly. It samples `sda_oe` in the cycle where SCL falls and again one cycle later. Register contents are checked only through bus reads, against a model built from the reset pattern and the write/read rules.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;

    // Bus-side phase of the target
    typedef enum logic [2:0] {
        PH_IDLE,    // no transaction
        PH_RX,      // shifting a byte in
        PH_RX_END,  // eight bits in, waiting for SCL low to decide
        PH_ACK,     // driving (or passing) the ninth bit
        PH_TX,      // shifting a byte out
        PH_TX_END,  // eight bits out, release before the host answers
        PH_HACK,    // host answers ACK or NACK
        PH_WAIT     // silent until START or STOP
    } phase_e;

    // Role of the byte being received
    typedef enum logic [1:0] {
        BY_ADDR,
        BY_CMD,
        BY_DATA
    } byte_e;

    typedef struct packed {
        phase_e     ph;
        byte_e      by;
        logic [2:0] bitc;
        logic       rd;
        logic [7:0] sh;
        logic       oe;
    } ctl_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    localparam logic [7:0] INIT_BASE = 8'hA0;

    function automatic logic [7:0] reg_init(input int unsigned idx);
        return 8'(32'(INIT_BASE) + idx);
    endfunction

endpackage

// File: rtl/smb_line_events.sv
module smb_line_events
    import smb_tgt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.rise  = scl_i & ~scl_q;
        ev.fall  = ~scl_i & scl_q;
        ev.start = scl_i & scl_q & sda_q & ~sda_i;
        ev.stop  = scl_i & scl_q & ~sda_q & sda_i;
        ev.sda   = sda_i;
    end

endmodule

// File: rtl/smb_ptr_unit.sv
module smb_ptr_unit #(
    parameter int NUM_REGS = 8,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rearm,    // any START
    input  logic             cmd_set,  // command byte accepted
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic             take,     // one data byte moved
    output logic [IDX_W-1:0] acc_idx   // index of the next access
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

    logic [IDX_W-1:0] ptr_q;
    logic             fresh_q;  // next access uses the pointer itself

    always_comb begin
        if (fresh_q)
            acc_idx = ptr_q;
        else if (ptr_q == LAST)
            acc_idx = '0;
        else
            acc_idx = ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            fresh_q <= 1'b1;
        end else if (cmd_set) begin
            ptr_q   <= cmd_idx;
            fresh_q <= 1'b1;
        end else if (take) begin
            ptr_q   <= acc_idx;
            fresh_q <= 1'b0;
        end else if (rearm) begin
            fresh_q <= 1'b1;
        end
    end

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smb_tgt_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);

    logic [7:0] regs [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++)
                regs[i] <= reg_init(i);
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    assign rd_data = regs[rd_idx];

endmodule

// File: rtl/smb_target_regs.sv
module smb_target_regs
    import smb_tgt_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [6:0] dev_addr,
    output logic       sda_oe
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    bus_ev_t          ev;
    ctl_t             ctl_q;
    ctl_t             ctl_d;
    logic             cmd_set;
    logic             take;
    logic             wr_en;
    logic [IDX_W-1:0] cmd_idx;
    logic [IDX_W-1:0] acc_idx;
    logic [7:0]       rd_data;

    smb_line_events u_ev (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    smb_ptr_unit #(.NUM_REGS(NUM_REGS)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .rearm   (ev.start),
        .cmd_set (cmd_set),
        .cmd_idx (cmd_idx),
        .take    (take),
        .acc_idx (acc_idx)
    );

    smb_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (acc_idx),
        .wr_data (ctl_q.sh),
        .rd_idx  (acc_idx),
        .rd_data (rd_data)
    );

    assign cmd_idx = IDX_W'({24'd0, ctl_q.sh} % NUM_REGS);

    always_comb begin
        ctl_d   = ctl_q;
        cmd_set = 1'b0;
        take    = 1'b0;
        wr_en   = 1'b0;
        if (ev.start) begin
            ctl_d.ph   = PH_RX;
            ctl_d.by   = BY_ADDR;
            ctl_d.bitc = '0;
            ctl_d.rd   = 1'b0;
            ctl_d.oe   = 1'b0;
        end else if (ev.stop) begin
            ctl_d.ph   = PH_IDLE;
            ctl_d.by   = BY_ADDR;
            ctl_d.bitc = '0;
            ctl_d.oe   = 1'b0;
        end else begin
            unique case (ctl_q.ph)
                PH_RX: begin
                    if (ev.rise) begin
                        ctl_d.sh   = {ctl_q.sh[6:0], ev.sda};
                        ctl_d.bitc = ctl_q.bitc + 3'd1;
                        if (ctl_q.bitc == 3'd7)
                            ctl_d.ph = PH_RX_END;
                    end
                end
                PH_RX_END: begin
                    if (ev.fall) begin
                        ctl_d.ph = PH_ACK;
                        ctl_d.oe = 1'b1;
                        unique case (ctl_q.by)
                            BY_ADDR: begin
                                if (ctl_q.sh[7:1] == dev_addr) begin
                                    ctl_d.rd = ctl_q.sh[0];
                                    ctl_d.by = BY_CMD;
                                end else begin
                                    ctl_d.ph = PH_WAIT;
                                    ctl_d.oe = 1'b0;
                                end
                            end
                            BY_CMD: begin
                                cmd_set  = 1'b1;
                                ctl_d.by = BY_DATA;
                            end
                            default: begin
                                wr_en = 1'b1;
                                take  = 1'b1;
                            end
                        endcase
                    end
                end
                PH_ACK: begin
                    if (ev.fall) begin
                        ctl_d.bitc = '0;
                        if (ctl_q.rd) begin
                            ctl_d.sh = rd_data;
                            ctl_d.oe = ~rd_data[7];
                            ctl_d.ph = PH_TX;
                            take     = 1'b1;
                        end else begin
                            ctl_d.oe = 1'b0;
                            ctl_d.ph = PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (ev.rise) begin
                        ctl_d.bitc = ctl_q.bitc + 3'd1;
                        if (ctl_q.bitc == 3'd7)
                            ctl_d.ph = PH_TX_END;
                    end else if (ev.fall) begin
                        ctl_d.sh = {ctl_q.sh[6:0], 1'b0};
                        ctl_d.oe = ~ctl_q.sh[6];
                    end
                end
                PH_TX_END: begin
                    if (ev.fall) begin
                        ctl_d.oe = 1'b0;
                        ctl_d.ph = PH_HACK;
                    end
                end
                PH_HACK: begin
                    if (ev.rise)
                        ctl_d.ph = ev.sda ? PH_WAIT : PH_ACK;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.ph   <= PH_IDLE;
            ctl_q.by   <= BY_ADDR;
            ctl_q.bitc <= '0;
            ctl_q.rd   <= 1'b0;
            ctl_q.sh   <= '0;
            ctl_q.oe   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_oe = ctl_q.oe;

endmodule

// File: rtl/smb_tgt_chk.sv
module smb_tgt_chk
    import smb_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_i,
    input logic       sda_oe,
    input logic [6:0] dev_addr,
    input phase_e     ph,
    input byte_e      by,
    input logic [2:0] bitc,
    input logic [7:0] shreg
);

    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_i;
            sda_p <= sda_i;
        end
    end

    logic start_seen, stop_seen, rise_seen, fall_seen;
    assign start_seen = scl_i & scl_p & sda_p & ~sda_i;
    assign stop_seen  = scl_i & scl_p & ~sda_p & sda_i;
    assign rise_seen  = scl_i & ~scl_p;
    assign fall_seen  = ~scl_i & scl_p;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_i)); // R9

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !sda_oe); // R3

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start_seen |=> (ph == PH_RX && bitc == 3'd0 && by == BY_ADDR)); // R3

    AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_RX_END && by == BY_ADDR && fall_seen && shreg[7:1] != dev_addr)
        |=> (ph == PH_WAIT && !sda_oe)); // R2

    AST_NACK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_HACK && rise_seen && sda_i) |=> (ph == PH_WAIT && !sda_oe)); // R8

    AST_SILENT_PHASES: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE || ph == PH_WAIT) |-> !sda_oe); // R2

endmodule

bind smb_target_regs smb_tgt_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_oe   (sda_oe),
    .dev_addr (dev_addr),
    .ph       (ctl_q.ph),
    .by       (ctl_q.by),
    .bitc     (ctl_q.bitc),
    .shreg    (ctl_q.sh)
);

// File: tb/sim_smb_target_regs.sv
module sim_smb_target_regs;

    localparam int Q = 4;  // clocks per bus phase

    localparam logic [7:0] OP_WB = 8'd1;  // write byte-data
    localparam logic [7:0] OP_WW = 8'd2;  // write word-data
    localparam logic [7:0] OP_RB = 8'd3;  // read byte-data
    localparam logic [7:0] OP_RW = 8'd4;  // read word-data
    localparam logic [7:0] OP_RX = 8'd5;  // receive byte

    // {op, cmd, data0, data1, expect0, expect1}; registers start at 0xA0+i
    localparam int NV = 11;
    localparam logic [47:0] VECS [NV] = '{
        {OP_RX, 8'h00, 8'h00, 8'h00, 8'hA0, 8'h00},
        {OP_RB, 8'h03, 8'h00, 8'h00, 8'hA3, 8'h00},
        {OP_RX, 8'h00, 8'h00, 8'h00, 8'hA3, 8'h00},
        {OP_WB, 8'h05, 8'h5A, 8'h00, 8'h00, 8'h00},
        {OP_RX, 8'h00, 8'h00, 8'h00, 8'h5A, 8'h00},
        {OP_WW, 8'h02, 8'h11, 8'h22, 8'h00, 8'h00},
        {OP_RW, 8'h02, 8'h00, 8'h00, 8'h11, 8'h22},
        {OP_RX, 8'h00, 8'h00, 8'h00, 8'h22, 8'h00},
        {OP_WW, 8'h07, 8'h33, 8'h44, 8'h00, 8'h00},
        {OP_RX, 8'h00, 8'h00, 8'h00, 8'h44, 8'h00},
        {OP_RW, 8'h07, 8'h00, 8'h00, 8'h33, 8'h44}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic [6:0] tgt_addr = 7'h3A;
    logic       sda_oe;
    logic       line;
    int         n_chk = 0;
    int         n_fail = 0;
    int         oe_hits = 0;

    always #4 clk = ~clk;

    assign line = sda_h & ~sda_oe;

    smb_target_regs #(.NUM_REGS(8)) u0 (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_h),
        .sda_i    (line),
        .dev_addr (tgt_addr),
        .sda_oe   (sda_oe)
    );

    always @(posedge clk) if (sda_oe) oe_hits++;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; hold();
        scl_h = 1'b1; hold();
        sda_h = 1'b0; hold();
        scl_h = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; hold();
        scl_h = 1'b1; hold();
        sda_h = 1'b1; hold();
    endtask

    task automatic clk_bit(input logic b, output logic r);
        sda_h = b;    hold();
        scl_h = 1'b1; hold();
        r = line;     hold();
        scl_h = 1'b0; hold();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], r);
        clk_bit(1'b1, r);
        acked = ~r;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, r);
            v[i] = r;
        end
        clk_bit(nack, r);
    endtask

    task automatic run_op(input logic [7:0] op, input logic [7:0] cmd,
                          input logic [7:0] d0, input logic [7:0] d1,
                          output logic [7:0] r0, output logic [7:0] r1,
                          output logic ok);
        logic a;
        ok = 1'b1; r0 = '0; r1 = '0;
        bus_start();
        if (op == OP_RX) begin
            send_byte({tgt_addr, 1'b1}, a); ok &= a;
            recv_byte(1'b1, r0);
        end else begin
            send_byte({tgt_addr, 1'b0}, a); ok &= a;
            send_byte(cmd, a); ok &= a;
            if (op == OP_WB || op == OP_WW) begin
                send_byte(d0, a); ok &= a;
                if (op == OP_WW) begin
                    send_byte(d1, a); ok &= a;
                end
            end else begin
                bus_start();
                send_byte({tgt_addr, 1'b1}, a); ok &= a;
                recv_byte(op == OP_RB, r0);
                if (op == OP_RW) recv_byte(1'b1, r1);
            end
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r0, r1, v;
        logic       ok, a, r;
        int         base;

        repeat (5) @(negedge clk);
        check("R10 sda released in reset", {15'd0, sda_oe}, 16'd0);
        rst = 1'b0;
        hold();
        check("R10 sda released after reset", {15'd0, sda_oe}, 16'd0);

        // table walk: R1 ack, R5 writes, R6 reads, R7 pointer reads
        for (int k = 0; k < NV; k++) begin
            logic [47:0] e;
            e = VECS[k];
            run_op(e[47:40], e[39:32], e[31:24], e[23:16], r0, r1, ok);
            check("R1 every byte acknowledged", {15'd0, ok}, 16'd1);
            if (e[47:40] == OP_RX)
                check("R7 receive byte returns pointer register", {8'd0, r0}, {8'd0, e[15:8]});
            else if (e[47:40] == OP_RB)
                check("R6 read byte-data", {8'd0, r0}, {8'd0, e[15:8]});
            else if (e[47:40] == OP_RW)
                check("R6 read word low then high", {r1, r0}, {e[7:0], e[15:8]});
        end

        // R4: command 0x0D selects register 5 (written 0x5A above)
        run_op(OP_RB, 8'h0D, 8'h00, 8'h00, r0, r1, ok);
        check("R4 command taken modulo register count", {7'd0, ok, r0}, {7'd0, 1'b1, 8'h5A});

        // R10: register 6 never written keeps its reset value
        run_op(OP_RB, 8'h06, 8'h00, 8'h00, r0, r1, ok);
        check("R10 reset value of untouched register", {8'd0, r0}, 16'h00A6);

        // R8: NACK after the low byte, then host keeps clocking
        bus_start();
        send_byte({tgt_addr, 1'b0}, a);
        send_byte(8'h02, a);
        bus_start();
        send_byte({tgt_addr, 1'b1}, a);
        recv_byte(1'b1, r0);
        check("R8 byte before nack", {8'd0, r0}, 16'h0011);
        base = oe_hits;
        recv_byte(1'b1, v);
        check("R8 no drive after nack", 16'(oe_hits - base), 16'd0);
        check("R8 line high after nack", {8'd0, v}, 16'h00FF);
        bus_stop();
        run_op(OP_RX, 8'h00, 8'h00, 8'h00, r0, r1, ok);
        check("R6 pointer left on last register read", {8'd0, r0}, 16'h0011);

        // R2: foreign address, attempted write to register 1
        base = oe_hits;
        bus_start();
        send_byte({tgt_addr ^ 7'h01, 1'b0}, a);
        check("R2 foreign address not acknowledged", {15'd0, a}, 16'd0);
        send_byte(8'h01, a);
        send_byte(8'hEE, a);
        bus_stop();
        check("R2 no drive for foreign address", 16'(oe_hits - base), 16'd0);
        run_op(OP_RB, 8'h01, 8'h00, 8'h00, r0, r1, ok);
        check("R2 register unchanged by foreign write", {8'd0, r0}, 16'h00A1);

        // R3: repeated START three bits into a data byte
        bus_start();
        send_byte({tgt_addr, 1'b0}, a);
        send_byte(8'h04, a);
        clk_bit(1'b1, r); clk_bit(1'b0, r); clk_bit(1'b1, r);
        bus_start();
        send_byte({tgt_addr, 1'b1}, a);
        check("R3 address after mid-byte restart acknowledged", {15'd0, a}, 16'd1);
        recv_byte(1'b1, r0);
        bus_stop();
        check("R3 partial byte discarded, pointer kept", {8'd0, r0}, 16'h00A4);

        // R9: acknowledge timing around the SCL falling edge
        bus_start();
        for (int i = 6; i >= 0; i--) clk_bit(tgt_addr[i], r);
        sda_h = 1'b0; hold();
        scl_h = 1'b1; hold(); hold();
        scl_h = 1'b0;
        check("R9 no drive in the SCL fall cycle", {15'd0, sda_oe}, 16'd0);
        @(negedge clk);
        check("R9 ack one cycle after SCL fall", {15'd0, sda_oe}, 16'd1);
        sda_h = 1'b1;
        hold();
        scl_h = 1'b1; hold();
        check("R1 SDA low on ninth clock", {15'd0, line}, 16'd0);
        hold();
        scl_h = 1'b0;
        @(negedge clk);
        check("R9 release one cycle after SCL fall", {15'd0, sda_oe}, 16'd0);
        hold();
        bus_stop();
        check("R3 released after STOP", {15'd0, sda_oe}, 16'd0);

        // R11: new address takes effect, old one is ignored
        tgt_addr = 7'h51;
        run_op(OP_RB, 8'h04, 8'h00, 8'h00, r0, r1, ok);
        check("R11 new address answered", {7'd0, ok, r0}, {7'd0, 1'b1, 8'hA4});
        bus_start();
        send_byte({7'h3A, 1'b1}, a);
        bus_stop();
        check("R11 old address ignored", {15'd0, a}, 16'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule